// File: doc/BRIEF.md
# Machine Check Request Controller

This block produces the active-low machine-check request that a bridge or memory controller sends to its host processor. An upstream error detector gives a one-cycle error pulse. The block then latches a pending request and holds it. It releases the request only when the host shows that it has entered the machine-check handler. The host shows this by fetching from one of two fixed eight-byte vector windows, one near the bottom of the address map and one near the top. The block finds such a fetch by watching the host bus address together with a transfer-start strobe and a read qualifier.

A configuration input sets how the pin is driven. In dedicated mode the block drives the pin at all times, at both levels. In shared mode the pin behaves as open drain: the block enables its driver only while a request is pending and always drives low, so other sources can pull the same wire without contention.

The controller is a two-state machine. The states are `MC_IDLE` (no request) and `MC_HOLD` (request pending). There are two transitions. `T_RAISE` goes from `MC_IDLE` to `MC_HOLD` on an error pulse. `T_TAKEN` goes from `MC_HOLD` to `MC_IDLE` on an acknowledging read. In every other case the machine keeps its current state.

Top module: `mcp_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in `MC_IDLE`. After the reset edge, `mc_pending` is 0. In shared mode `mc_oe` is 0; in dedicated mode `mc_oe` is 1 and `mc_out_n` is 1.
- R2: An error pulse seen in `MC_IDLE` sets `mc_pending` to 1 from the following clock edge (transition `T_RAISE`).
- R3: While pending, the request stays asserted until an acknowledging read occurs. Idle cycles and reads outside both vector windows do not clear it.
- R4: A read that starts (`bus_ts`=1, `bus_rd`=1) at any byte address from 0x0000_0200 to 0x0000_0207 clears `mc_pending` at that clock edge (transition `T_TAKEN`). Addresses 0x0000_01FF and 0x0000_0208 do not clear it.
- R5: A started read at any byte address from 0xFFF0_0200 to 0xFFF0_0207 also clears `mc_pending`. Address 0xFFF0_0208 does not clear it.
- R6: A transfer with `bus_rd`=0 (a write) to either vector window has no effect on the request.
- R7: With `cfg_shared`=0 (dedicated mode), `mc_oe` is 1 at all times and `mc_out_n` is the inverse of `mc_pending`.
- R8: With `cfg_shared`=1 (shared mode), `mc_oe` equals `mc_pending` and `mc_out_n` is 0.
- R9: An error pulse while already pending neither re-triggers nor extends the request. If an error and an acknowledging read arrive together while pending, the request clears. A new request needs a new error pulse after the clear.
- R10: A read address in a vector window with `bus_ts`=0 is not an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_pulse | input | 1 | One-cycle error-detected strobe |
| bus_ts | input | 1 | Host transfer-start qualifier |
| bus_rd | input | 1 | 1 = read transfer, 0 = write |
| bus_addr | input | 32 | Host byte address of the transfer |
| cfg_shared | input | 1 | 0 = pin always driven, 1 = open-drain sharing |
| mc_out_n | output | 1 | Machine-check request level, active low |
| mc_oe | output | 1 | Output enable for the request pin |
| mc_pending | output | 1 | Request currently held |

## Verification
The state register is the only storage. An error pulse or an acknowledging read shows on `mc_pending` right after the clock edge where it was sampled, so each result is due one cycle after its stimulus. The pin outputs follow the mode input within the same cycle, because they are combinational. The driver applies each stimulus on the falling edge and queues the expected outputs for the next rising edge. The monitor then compares them five nanoseconds after that rising edge, once the state has settled. The window-boundary addresses, writes, reads without a transfer start, errors during a pending request, and mode changes are each given as one queued step, so every outcome is checked in the cycle it is due.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic {
        MC_IDLE = 1'b0,
        MC_HOLD = 1'b1
    } mc_state_t;

    localparam int MC_ADDR_W  = 32;
    localparam int MC_NUM_WIN = 2;
    localparam int MC_WIN_LG2 = 3;
endpackage

// File: rtl/mc_vec_decode.sv
module mc_vec_decode #(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 2,
    parameter int WIN_LG2 = 3,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TAG_W = ADDR_W - WIN_LG2;

    logic [NUM_WIN-1:0] win_hit;

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_win
            localparam logic [TAG_W-1:0] TAG = WIN_BASE[w][ADDR_W-1:WIN_LG2];
            assign win_hit[w] = (addr[ADDR_W-1:WIN_LG2] == TAG);
        end
    endgenerate

    assign hit = |win_hit;
endmodule

// File: rtl/mc_fsm.sv
module mc_fsm
    import mc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic taken,
    output logic pending
);
    mc_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= MC_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MC_IDLE: if (raise) state_d = MC_HOLD;   // T_RAISE
            MC_HOLD: if (taken) state_d = MC_IDLE;   // T_TAKEN
            default: state_d = MC_IDLE;
        endcase
    end

    always_comb begin
        pending = 1'b0;
        unique case (state_q)
            MC_IDLE: pending = 1'b0;
            MC_HOLD: pending = 1'b1;
            default: pending = 1'b0;
        endcase
    end
endmodule

// File: rtl/mc_pin_drive.sv
module mc_pin_drive (
    input  logic shared,
    input  logic pending,
    output logic out_n,
    output logic oe
);
    always_comb begin
        if (shared) begin
            oe    = pending;
            out_n = 1'b0;
        end else begin
            oe    = 1'b1;
            out_n = ~pending;
        end
    end
endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
    import mc_pkg::*;
#(
    parameter int ADDR_W = MC_ADDR_W,
    parameter logic [ADDR_W-1:0] LOW_VEC  = 32'h0000_0200,
    parameter logic [ADDR_W-1:0] HIGH_VEC = 32'hFFF0_0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_pulse,
    input  logic              bus_ts,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              cfg_shared,
    output logic              mc_out_n,
    output logic              mc_oe,
    output logic              mc_pending
);
    localparam logic [MC_NUM_WIN-1:0][ADDR_W-1:0] BASES = {HIGH_VEC, LOW_VEC};

    logic vec_hit;
    logic taken;
    logic pend;

    mc_vec_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_WIN (MC_NUM_WIN),
        .WIN_LG2 (MC_WIN_LG2),
        .WIN_BASE(BASES)
    ) u_dec (
        .addr(bus_addr),
        .hit (vec_hit)
    );

    assign taken = bus_ts & bus_rd & vec_hit;

    mc_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .raise  (err_pulse),
        .taken  (taken),
        .pending(pend)
    );

    mc_pin_drive u_pin (
        .shared (cfg_shared),
        .pending(pend),
        .out_n  (mc_out_n),
        .oe     (mc_oe)
    );

    assign mc_pending = pend;
endmodule

// File: rtl/mcp_ctrl_chk.sv
module mcp_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        err_pulse,
    input logic        bus_ts,
    input logic        bus_rd,
    input logic [31:0] bus_addr,
    input logic        cfg_shared,
    input logic        mc_out_n,
    input logic        mc_oe,
    input logic        mc_pending
);
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> !mc_pending);

    a_r2_raise: assert property (@(posedge clk) disable iff (rst)
        (!mc_pending && err_pulse) |=> mc_pending);

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (mc_pending && !(bus_ts && bus_rd)) |=> mc_pending);

    a_r4_low_ack: assert property (@(posedge clk) disable iff (rst)
        (mc_pending && bus_ts && bus_rd && bus_addr[31:3] == 29'h40) |=> !mc_pending);

    a_r6_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (mc_pending && bus_ts && !bus_rd) |=> mc_pending);

    a_r7_dedicated: assert property (@(posedge clk) disable iff (rst)
        !cfg_shared |-> (mc_oe && mc_out_n == !mc_pending));

    a_r8_shared: assert property (@(posedge clk) disable iff (rst)
        cfg_shared |-> (mc_oe == mc_pending && !mc_out_n));
endmodule

bind mcp_ctrl mcp_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .err_pulse (err_pulse),
    .bus_ts    (bus_ts),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .cfg_shared(cfg_shared),
    .mc_out_n  (mc_out_n),
    .mc_oe     (mc_oe),
    .mc_pending(mc_pending)
);

// File: tb/sim_mcp_ctrl.sv
module sim_mcp_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_pulse = 1'b0;
    logic        bus_ts = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        cfg_shared = 1'b0;
    logic        mc_out_n, mc_oe, mc_pending;

    always #10 clk = ~clk;   // 50 MHz

    mcp_ctrl u0 (
        .clk(clk), .rst(rst), .err_pulse(err_pulse), .bus_ts(bus_ts),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .cfg_shared(cfg_shared),
        .mc_out_n(mc_out_n), .mc_oe(mc_oe), .mc_pending(mc_pending)
    );

    typedef struct {
        logic  pend;
        logic  oe;
        logic  out_n;
        string tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    logic model_pend = 1'b0;
    bit   done = 1'b0;

    function automatic logic in_vec(input logic [31:0] a);
        return (a >= 32'h0000_0200 && a <= 32'h0000_0207) ||
               (a >= 32'hFFF0_0200 && a <= 32'hFFF0_0207);
    endfunction

    task automatic step(input logic r, input logic e, input logic ts, input logic rd,
                        input logic [31:0] a, input logic sh, input string tag);
        exp_t x;
        @(negedge clk);
        rst = r; err_pulse = e; bus_ts = ts; bus_rd = rd; bus_addr = a; cfg_shared = sh;
        if (r)               model_pend = 1'b0;
        else if (!model_pend) model_pend = e;
        else if (ts && rd && in_vec(a)) model_pend = 1'b0;
        x.pend  = model_pend;
        x.oe    = sh ? model_pend : 1'b1;
        x.out_n = sh ? 1'b0 : ~model_pend;
        x.tag   = tag;
        q.push_back(x);
    endtask

    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            total++;
            if ({mc_pending, mc_oe, mc_out_n} !== {x.pend, x.oe, x.out_n}) begin
                bad++;
                $display("FAIL %s: pend/oe/out_n actual=%b%b%b expected=%b%b%b",
                         x.tag, mc_pending, mc_oe, mc_out_n, x.pend, x.oe, x.out_n);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset in both modes
        step(1, 0, 0, 0, 32'h0, 1, "R1 shared reset");
        step(1, 0, 0, 0, 32'h0, 0, "R1 dedicated reset");
        // R2 raise, R7 dedicated drive
        step(0, 1, 0, 0, 32'h0, 0, "R2 raise / R7");
        step(0, 0, 0, 0, 32'h0, 0, "R3 hold idle");
        // R3 reads outside windows
        step(0, 0, 1, 1, 32'h0000_01FF, 0, "R4 below low window");
        step(0, 0, 1, 1, 32'h0000_0208, 0, "R4 above low window");
        step(0, 0, 1, 1, 32'h1234_5678, 0, "R3 unrelated read");
        // R6 write to window
        step(0, 0, 1, 0, 32'h0000_0200, 0, "R6 write low window");
        step(0, 0, 1, 0, 32'hFFF0_0204, 0, "R6 write high window");
        // R10 no transfer start
        step(0, 0, 0, 1, 32'h0000_0203, 0, "R10 no ts");
        // R9 error during pending
        step(0, 1, 0, 0, 32'h0, 0, "R9 error while pending");
        // R4 clear at top byte of low window
        step(0, 0, 1, 1, 32'h0000_0207, 0, "R4 low window ack");
        step(0, 0, 0, 0, 32'h0, 0, "R9 stays clear");
        // R8 shared mode
        step(0, 0, 0, 0, 32'h0, 1, "R8 shared idle");
        step(0, 1, 0, 0, 32'h0, 1, "R8 shared raise");
        step(0, 0, 1, 1, 32'hFFF0_0208, 1, "R5 above high window");
        step(0, 0, 1, 1, 32'hFFF0_0200, 1, "R5 high window ack");
        // R9 error and ack together while pending
        step(0, 1, 0, 0, 32'h0, 1, "R2 raise again");
        step(0, 1, 1, 1, 32'h0000_0200, 1, "R9 error with ack");
        // error and ack together in idle raises
        step(0, 1, 1, 1, 32'hFFF0_0207, 1, "R2 raise with ack in idle");
        step(0, 0, 1, 1, 32'hFFF0_0207, 0, "R5 high top byte / R7");
        // R1 reset while pending, shared
        step(0, 1, 0, 0, 32'h0, 1, "R2 raise before reset");
        step(1, 0, 0, 0, 32'h0, 1, "R1 reset releases pin");
        step(0, 0, 0, 0, 32'h0, 1, "R1 idle after reset");
        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule